// File: doc/BRIEF.md
# Page Translation Controller with Accessed/Dirty Maintenance

This block sequences one virtual-to-physical translation for a three-level, 39-bit virtual address scheme. A request is first looked up in a translation cache. On a miss a page-table walker is started. The leaf entry that results, whether cached or walked, is checked against the access kind and privilege. The controller then decides whether the entry's accessed or dirty flag has to be raised. The walker and the cache are external. This block only drives their control and data lines.

When a flag has to change, a configuration input picks what happens. Either the translation faults with a PTE-update code, or the block writes the new entry back to memory with a single 64-bit write. After a successful write-back it refreshes the cache: a new fill after a miss, or an in-place rewrite of the entry after a hit. Each translation ends with a one-cycle completion pulse. The pulse carries either a physical address or a fault code.

Top module: `xlc_xlate_ctrl`

## Requirements
- R1: While reset is active and after it is released, the block is idle. `req_ready` is 1, and `done`, `walk_start`, `mem_wr_valid`, `cache_fill` and `cache_upd` are 0.
- R2: A request accepted in idle is looked up in the cache in the next cycle, with `cache_vaddr` equal to the request address. On a hit that passes the permission check and needs no flag change, the cache's physical address is returned. No walk, memory write or cache write takes place.
- R3: Entry flag bits are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7. Access codes are 0 load, 1 store, 2 fetch, and 3 is handled as a load. User mode needs U=1. Supervisor mode needs U=0, or `cfg_sum`=1 with a non-fetch access. A fetch needs X, a store needs W, and a load needs R, or X with `cfg_mxr`=1. A failure on either path ends with fault code 4 and nothing is written.
- R4: A flag change is needed when A=0, or when the access is a store and D=0. The new entry sets A, and for a store it also sets D. All other bits are unchanged.
- R5: If a change is needed and `cfg_hw_ad`=0, the result is fault code 5. There is no memory write and no cache write.
- R6: If a change is needed and `cfg_hw_ad`=1, `mem_wr_valid` is raised with the stored entry address and the new entry. Address and data hold until `mem_wr_done`.
- R7: On a miss, `walk_start` pulses with `walk_vaddr` equal to the request address. A successful walk that needs no change fills the cache with the walked entry and returns the walker's physical address.
- R8: On a miss with a write-back, the cache fill is not issued before the write completes, and the filled entry is the updated one.
- R9: A write-back answered with `mem_wr_err` ends with access fault code 1, on both the hit and the miss path. No fill and no cache rewrite follow.
- R10: On a hit with a successful write-back, `cache_upd` pulses with the updated entry and no fill is issued.
- R11: A walker fault is reported with the walker's own nonzero code, unchanged.
- R12: `done` is high for exactly one cycle per request. `done_paddr` is 0 whenever `done_fault` is 1. The block is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw_ad | input | 1 | 1: write back flag changes; 0: fault instead |
| cfg_mxr | input | 1 | Loads may use execute-only pages |
| cfg_sum | input | 1 | Supervisor may load/store user pages |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| cache_lookup | output | 1 | Cache lookup strobe |
| cache_vaddr | output | VA_W | Address for lookup, fill and rewrite |
| cache_hit | input | 1 | Lookup hit, valid with the strobe |
| cache_pte | input | PTE_W | Cached leaf entry |
| cache_pte_addr | input | PA_W | Memory address of the cached entry |
| cache_paddr | input | PA_W | Physical address from the cache |
| cache_fill | output | 1 | Insert a new cache entry |
| cache_upd | output | 1 | Rewrite the hit entry's leaf value |
| cache_wr_pte | output | PTE_W | Entry value for fill or rewrite |
| cache_wr_pte_addr | output | PA_W | Entry address for fill |
| cache_wr_paddr | output | PA_W | Physical address for fill |
| walk_start | output | 1 | Start a walk |
| walk_vaddr | output | VA_W | Address to walk |
| walk_done | input | 1 | Walk finished |
| walk_fault | input | 1 | Walk ended in a fault |
| walk_code | input | 3 | Walker fault code |
| walk_pte | input | PTE_W | Walked leaf entry |
| walk_pte_addr | input | PA_W | Memory address of walked entry |
| walk_paddr | input | PA_W | Physical address from the walk |
| mem_wr_valid | output | 1 | Entry write request |
| mem_wr_addr | output | PA_W | Write address |
| mem_wr_data | output | PTE_W | Write data (8 bytes) |
| mem_wr_done | input | 1 | Write finished |
| mem_wr_err | input | 1 | Write failed, valid with done |
| done | output | 1 | Completion pulse |
| done_fault | output | 1 | Translation faulted |
| done_code | output | 3 | Fault code |
| done_paddr | output | PA_W | Physical address |

## Verification
The assertions watch on every cycle that the completion pulse lasts one cycle and that a pending write holds its address and data. They also check that every written-back or filled entry carries A=1, that fill and in-place rewrite are never issued together, and that a fill never coincides with an unfinished or failed write. Only the bench scenarios can show that the right outcome is chosen for each combination of hit or miss, privilege, access kind, flag state, update mode and write error. The same holds for the exact fault codes and for the returned addresses.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOOKUP    = 3'd1,
    ST_WALK      = 3'd2,
    ST_WRITEBACK = 3'd3,
    ST_DONE      = 3'd4
  } xlc_state_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int PB_R = 1;
  localparam int PB_W = 2;
  localparam int PB_X = 3;
  localparam int PB_U = 4;
  localparam int PB_A = 6;
  localparam int PB_D = 7;

  localparam int FC_W = 3;
  localparam logic [FC_W-1:0] FC_NONE    = 3'd0;
  localparam logic [FC_W-1:0] FC_ACCESS  = 3'd1;
  localparam logic [FC_W-1:0] FC_PERM    = 3'd4;
  localparam logic [FC_W-1:0] FC_PTE_UPD = 3'd5;
endpackage

// File: rtl/xlc_perm_check.sv
module xlc_perm_check
  import xlc_pkg::*;
(
  input  logic       pte_r,
  input  logic       pte_w,
  input  logic       pte_x,
  input  logic       pte_u,
  input  logic [1:0] acc,
  input  logic       user_mode,
  input  logic       mxr,
  input  logic       sum,
  output logic       ok
);
  logic is_fetch;
  logic is_store;
  logic mode_ok;
  logic kind_ok;

  always_comb begin
    is_fetch = (acc == ACC_FETCH);
    is_store = (acc == ACC_STORE);
    if (user_mode) mode_ok = pte_u;
    else           mode_ok = !pte_u || (sum && !is_fetch);
    if (is_fetch)      kind_ok = pte_x;
    else if (is_store) kind_ok = pte_w;
    else               kind_ok = pte_r || (mxr && pte_x);
    ok = mode_ok && kind_ok;
  end
endmodule

// File: rtl/xlc_ad_update.sv
module xlc_ad_update
  import xlc_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_in,
  input  logic [1:0]       acc,
  output logic             need,
  output logic [PTE_W-1:0] pte_out
);
  logic             is_store;
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    is_store       = (acc == ACC_STORE);
    set_mask       = '0;
    set_mask[PB_A] = 1'b1;
    set_mask[PB_D] = is_store;
    need    = !pte_in[PB_A] || (is_store && !pte_in[PB_D]);
    pte_out = pte_in | set_mask;
  end
endmodule

// File: rtl/xlc_xlate_ctrl.sv
module xlc_xlate_ctrl
  import xlc_pkg::*;
#(
  parameter int VA_W  = 39,
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hw_ad,
  input  logic             cfg_mxr,
  input  logic             cfg_sum,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  output logic             cache_lookup,
  output logic [VA_W-1:0]  cache_vaddr,
  input  logic             cache_hit,
  input  logic [PTE_W-1:0] cache_pte,
  input  logic [PA_W-1:0]  cache_pte_addr,
  input  logic [PA_W-1:0]  cache_paddr,
  output logic             cache_fill,
  output logic             cache_upd,
  output logic [PTE_W-1:0] cache_wr_pte,
  output logic [PA_W-1:0]  cache_wr_pte_addr,
  output logic [PA_W-1:0]  cache_wr_paddr,
  output logic             walk_start,
  output logic [VA_W-1:0]  walk_vaddr,
  input  logic             walk_done,
  input  logic             walk_fault,
  input  logic [2:0]       walk_code,
  input  logic [PTE_W-1:0] walk_pte,
  input  logic [PA_W-1:0]  walk_pte_addr,
  input  logic [PA_W-1:0]  walk_paddr,
  output logic             mem_wr_valid,
  output logic [PA_W-1:0]  mem_wr_addr,
  output logic [PTE_W-1:0] mem_wr_data,
  input  logic             mem_wr_done,
  input  logic             mem_wr_err,
  output logic             done,
  output logic             done_fault,
  output logic [2:0]       done_code,
  output logic [PA_W-1:0]  done_paddr
);
  localparam logic [PA_W-1:0] PA_ZERO = '0;

  xlc_state_e       state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic             from_hit_q;
  logic [PTE_W-1:0] wb_pte_q;
  logic [PA_W-1:0]  wb_addr_q;
  logic [PA_W-1:0]  wb_paddr_q;
  logic [PA_W-1:0]  res_paddr_q;
  logic             res_fault_q;
  logic [2:0]       res_code_q;

  logic             req_ld, wb_ld, res_ld;
  logic [PA_W-1:0]  res_paddr_d;
  logic             res_fault_d;
  logic [2:0]       res_code_d;
  logic             fill_now, upd_now;

  logic             in_lookup, in_walk, in_wb;
  logic             decide_fire;
  logic [PTE_W-1:0] ev_pte;
  logic [PA_W-1:0]  ev_pte_addr;
  logic [PA_W-1:0]  ev_paddr;
  logic             perm_ok;
  logic             ad_need;
  logic [PTE_W-1:0] ad_pte;

  assign in_lookup   = (state_q == ST_LOOKUP);
  assign in_walk     = (state_q == ST_WALK);
  assign in_wb       = (state_q == ST_WRITEBACK);
  assign decide_fire = (in_lookup && cache_hit) || (in_walk && walk_done && !walk_fault);
  assign ev_pte      = in_lookup ? cache_pte      : walk_pte;
  assign ev_pte_addr = in_lookup ? cache_pte_addr : walk_pte_addr;
  assign ev_paddr    = in_lookup ? cache_paddr    : walk_paddr;

  xlc_perm_check u_perm (
    .pte_r     (ev_pte[PB_R]),
    .pte_w     (ev_pte[PB_W]),
    .pte_x     (ev_pte[PB_X]),
    .pte_u     (ev_pte[PB_U]),
    .acc       (acc_q),
    .user_mode (user_q),
    .mxr       (cfg_mxr),
    .sum       (cfg_sum),
    .ok        (perm_ok)
  );

  xlc_ad_update #(.PTE_W(PTE_W)) u_ad (
    .pte_in  (ev_pte),
    .acc     (acc_q),
    .need    (ad_need),
    .pte_out (ad_pte)
  );

  // Next-state and load-enable decode
  always_comb begin
    state_d     = state_q;
    req_ld      = 1'b0;
    wb_ld       = 1'b0;
    res_ld      = 1'b0;
    res_paddr_d = PA_ZERO;
    res_fault_d = 1'b0;
    res_code_d  = FC_NONE;
    fill_now    = 1'b0;
    upd_now     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_LOOKUP;
          req_ld  = 1'b1;
        end
      end
      ST_LOOKUP: begin
        if (!cache_hit) state_d = ST_WALK;
      end
      ST_WALK: begin
        if (walk_done && walk_fault) begin
          state_d     = ST_DONE;
          res_ld      = 1'b1;
          res_fault_d = 1'b1;
          res_code_d  = walk_code;
        end
      end
      ST_WRITEBACK: begin
        if (mem_wr_done) begin
          state_d = ST_DONE;
          res_ld  = 1'b1;
          if (mem_wr_err) begin
            res_fault_d = 1'b1;
            res_code_d  = FC_ACCESS;
          end else begin
            res_paddr_d = wb_paddr_q;
            fill_now    = !from_hit_q;
            upd_now     = from_hit_q;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    if (decide_fire) begin
      state_d = ST_DONE;
      res_ld  = 1'b1;
      if (!perm_ok) begin
        res_fault_d = 1'b1;
        res_code_d  = FC_PERM;
      end else if (!ad_need) begin
        res_paddr_d = ev_paddr;
        fill_now    = in_walk;
      end else if (!cfg_hw_ad) begin
        res_fault_d = 1'b1;
        res_code_d  = FC_PTE_UPD;
      end else begin
        state_d = ST_WRITEBACK;
        res_ld  = 1'b0;
        wb_ld   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      acc_q  <= ACC_LOAD;
      user_q <= 1'b0;
    end else if (req_ld) begin
      va_q   <= req_vaddr;
      acc_q  <= req_acc;
      user_q <= req_user;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      from_hit_q <= 1'b0;
      wb_pte_q   <= '0;
      wb_addr_q  <= '0;
      wb_paddr_q <= '0;
    end else if (wb_ld) begin
      from_hit_q <= in_lookup;
      wb_pte_q   <= ad_pte;
      wb_addr_q  <= ev_pte_addr;
      wb_paddr_q <= ev_paddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_paddr_q <= '0;
      res_fault_q <= 1'b0;
      res_code_q  <= FC_NONE;
    end else if (res_ld) begin
      res_paddr_q <= res_paddr_d;
      res_fault_q <= res_fault_d;
      res_code_q  <= res_code_d;
    end
  end

  assign req_ready         = (state_q == ST_IDLE);
  assign cache_lookup      = in_lookup;
  assign cache_vaddr       = va_q;
  assign walk_start        = in_lookup && !cache_hit;
  assign walk_vaddr        = va_q;
  assign mem_wr_valid      = in_wb;
  assign mem_wr_addr       = wb_addr_q;
  assign mem_wr_data       = wb_pte_q;
  assign cache_fill        = fill_now;
  assign cache_upd         = upd_now;
  assign cache_wr_pte      = in_wb ? wb_pte_q   : walk_pte;
  assign cache_wr_pte_addr = in_wb ? wb_addr_q  : walk_pte_addr;
  assign cache_wr_paddr    = in_wb ? wb_paddr_q : walk_paddr;
  assign done              = (state_q == ST_DONE);
  assign done_fault        = res_fault_q;
  assign done_code         = res_code_q;
  assign done_paddr        = res_paddr_q;
endmodule

// File: rtl/xlc_xlate_ctrl_sva.sv
module xlc_xlate_ctrl_sva
  import xlc_pkg::*;
#(
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             done_fault,
  input logic [2:0]       done_code,
  input logic             mem_wr_valid,
  input logic [PA_W-1:0]  mem_wr_addr,
  input logic [PTE_W-1:0] mem_wr_data,
  input logic             mem_wr_done,
  input logic             mem_wr_err,
  input logic             cache_fill,
  input logic             cache_upd,
  input logic [PTE_W-1:0] cache_wr_pte
);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_code != 3'd0));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_done) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_wr_sets_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_wr_data[PB_A]);

  assert_fill_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_fill && mem_wr_valid) |-> (mem_wr_done && !mem_wr_err));

  assert_fill_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_fill || cache_upd) |-> cache_wr_pte[PB_A]);

  assert_one_cache_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_fill && cache_upd));

  assert_err_no_cache_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_done && mem_wr_err) |-> (!cache_fill && !cache_upd));
endmodule

bind xlc_xlate_ctrl xlc_xlate_ctrl_sva #(.PA_W(PA_W), .PTE_W(PTE_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .done_fault   (done_fault),
  .done_code    (done_code),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_done  (mem_wr_done),
  .mem_wr_err   (mem_wr_err),
  .cache_fill   (cache_fill),
  .cache_upd    (cache_upd),
  .cache_wr_pte (cache_wr_pte)
);

// File: tb/xlc_xlate_ctrl_bench.sv
module xlc_xlate_ctrl_bench;
  localparam int VA_W = 39;
  localparam int PA_W = 56;
  localparam int PTE_W = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_hw_ad, cfg_mxr, cfg_sum;
  logic req_valid, req_ready, req_user;
  logic [VA_W-1:0] req_vaddr;
  logic [1:0] req_acc;
  logic cache_lookup, cache_hit, cache_fill, cache_upd;
  logic [VA_W-1:0] cache_vaddr, walk_vaddr;
  logic [PTE_W-1:0] cache_pte, cache_wr_pte, walk_pte, mem_wr_data;
  logic [PA_W-1:0] cache_pte_addr, cache_paddr, cache_wr_pte_addr, cache_wr_paddr;
  logic walk_start, walk_done, walk_fault;
  logic [2:0] walk_code, done_code;
  logic [PA_W-1:0] walk_pte_addr, walk_paddr, mem_wr_addr, done_paddr;
  logic mem_wr_valid, mem_wr_done, mem_wr_err;
  logic done, done_fault;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xlc_xlate_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_xlc_xlate_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_hw_ad(cfg_hw_ad), .cfg_mxr(cfg_mxr), .cfg_sum(cfg_sum),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .req_user(req_user), .cache_lookup(cache_lookup), .cache_vaddr(cache_vaddr),
    .cache_hit(cache_hit), .cache_pte(cache_pte), .cache_pte_addr(cache_pte_addr),
    .cache_paddr(cache_paddr), .cache_fill(cache_fill), .cache_upd(cache_upd),
    .cache_wr_pte(cache_wr_pte), .cache_wr_pte_addr(cache_wr_pte_addr),
    .cache_wr_paddr(cache_wr_paddr), .walk_start(walk_start), .walk_vaddr(walk_vaddr),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_code(walk_code),
    .walk_pte(walk_pte), .walk_pte_addr(walk_pte_addr), .walk_paddr(walk_paddr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_done(mem_wr_done), .mem_wr_err(mem_wr_err), .done(done),
    .done_fault(done_fault), .done_code(done_code), .done_paddr(done_paddr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Permission rule as stated in R3
  function automatic bit allowed(input logic [7:0] f, input logic [1:0] acc,
                                 input bit user, input bit mxr, input bit sum);
    bit priv_pass, kind_pass;
    priv_pass = user ? f[4] : (f[4] == 1'b0 || (sum && acc != 2'd2));
    case (acc)
      2'd1:    kind_pass = f[2];
      2'd2:    kind_pass = f[3];
      default: kind_pass = f[1] || (mxr && f[3]);
    endcase
    return priv_pass && kind_pass;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic run_txn(input bit hit, input logic [63:0] cpte, input bit wf, input logic [2:0] wc,
                         input logic [63:0] wpte, input logic [1:0] acc, input bit user,
                         input bit mxr, input bit sum, input bit hwad, input bit werr);
    logic [VA_W-1:0] va;
    logic [PA_W-1:0] cpa, caddr, wpa, waddr, e_paddr, e_waddr;
    logic [63:0] p, np, e_wdata, e_fpte;
    logic [PA_W-1:0] ep_addr, epa;
    bit e_fault, e_wr, e_fill, e_upd, need;
    logic [2:0] e_code;
    string tg;
    int wlat, mlat, wcnt, mcnt, nwalk;
    bit wr_seen, fill_seen, upd_seen, got_done, mem_done_seen, order_ok;
    logic [PA_W-1:0] s_waddr, s_fpaddr, s_fpa_addr;
    logic [63:0] s_wdata, s_fpte, s_upte;
    logic [PA_W-1:0] s_dpaddr;
    logic s_dfault;
    logic [2:0] s_dcode;
    logic [VA_W-1:0] s_cva, s_wva;

    va = rnd64()[VA_W-1:0];
    cpa = rnd64()[PA_W-1:0]; caddr = rnd64()[PA_W-1:0];
    wpa = rnd64()[PA_W-1:0]; waddr = rnd64()[PA_W-1:0];
    wlat = 1 + int'($urandom_range(0, 3));
    mlat = 1 + int'($urandom_range(0, 3));

    // Expected outcome from the requirements
    p = hit ? cpte : wpte; epa = hit ? cpa : wpa; ep_addr = hit ? caddr : waddr;
    e_fault = 0; e_code = 3'd0; e_paddr = '0; e_wr = 0; e_fill = 0; e_upd = 0;
    e_wdata = '0; e_waddr = '0; e_fpte = '0;
    need = (p[6] == 1'b0) || (acc == 2'd1 && p[7] == 1'b0);
    np = p | 64'h40 | ((acc == 2'd1) ? 64'h80 : 64'h0);
    if (!hit && wf) begin
      e_fault = 1; e_code = wc; tg = "R11";
    end else if (!allowed(p[7:0], acc, user, mxr, sum)) begin
      e_fault = 1; e_code = 3'd4; tg = "R3";
    end else if (!need) begin
      e_paddr = epa; e_fill = !hit; e_fpte = p; tg = hit ? "R2" : "R7";
    end else if (!hwad) begin
      e_fault = 1; e_code = 3'd5; tg = "R5";
    end else begin
      e_wr = 1; e_wdata = np; e_waddr = ep_addr;
      if (werr) begin
        e_fault = 1; e_code = 3'd1; tg = "R9";
      end else begin
        e_paddr = epa; e_fill = !hit; e_upd = hit; e_fpte = np; tg = hit ? "R10" : "R8";
      end
    end

    cfg_hw_ad = hwad; cfg_mxr = mxr; cfg_sum = sum;
    cache_hit = hit; cache_pte = cpte; cache_pte_addr = caddr; cache_paddr = cpa;
    walk_fault = wf; walk_code = wc; walk_pte = wpte; walk_pte_addr = waddr; walk_paddr = wpa;
    walk_done = 0; mem_wr_done = 0; mem_wr_err = 0;

    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc; req_user = user;
    @(negedge clk);
    req_valid = 0;
    s_cva = cache_vaddr;
    wcnt = -1; mcnt = -1; nwalk = 0; wr_seen = 0; fill_seen = 0; upd_seen = 0;
    got_done = 0; mem_done_seen = 0; order_ok = 1;
    s_waddr = '0; s_wdata = '0; s_fpte = '0; s_upte = '0; s_fpaddr = '0; s_fpa_addr = '0;
    s_dpaddr = '0; s_dfault = 0; s_dcode = 0; s_wva = '0;
    for (int cyc = 0; cyc < 40 && !got_done; cyc++) begin
      walk_done = 0; mem_wr_done = 0; mem_wr_err = 0;
      if (wcnt > 0) begin wcnt--; if (wcnt == 0) walk_done = 1; end
      if (mcnt > 0) begin mcnt--; if (mcnt == 0) begin mem_wr_done = 1; mem_wr_err = werr; end end
      #1;
      if (walk_start) begin nwalk++; wcnt = wlat; s_wva = walk_vaddr; end
      if (mem_wr_valid && mcnt < 0) begin
        wr_seen = 1; s_waddr = mem_wr_addr; s_wdata = mem_wr_data; mcnt = mlat;
      end
      if (mem_wr_done) mem_done_seen = 1;
      if (cache_fill) begin
        fill_seen = 1; s_fpte = cache_wr_pte; s_fpaddr = cache_wr_paddr; s_fpa_addr = cache_wr_pte_addr;
        if (e_wr && !mem_done_seen) order_ok = 0;
      end
      if (cache_upd) begin upd_seen = 1; s_upte = cache_wr_pte; end
      if (done) begin
        got_done = 1; s_dpaddr = done_paddr; s_dfault = done_fault; s_dcode = done_code;
      end
      @(negedge clk);
    end
    walk_done = 0; mem_wr_done = 0; mem_wr_err = 0;

    chk(got_done, "R12", "completion seen", 64'(got_done), 64'd1);
    chk(s_cva == va, "R2", "lookup address", 64'(s_cva), 64'(va));
    chk(s_dfault == e_fault && s_dcode == e_code, tg, "fault/code",
        {s_dfault, 60'd0, s_dcode}, {e_fault, 60'd0, e_code});
    chk(s_dpaddr == e_paddr, e_fault ? "R12" : tg, "done_paddr", 64'(s_dpaddr), 64'(e_paddr));
    chk(nwalk == (hit ? 0 : 1), "R7", "walk starts", 64'(nwalk), hit ? 64'd0 : 64'd1);
    if (!hit) chk(s_wva == va, "R7", "walk address", 64'(s_wva), 64'(va));
    chk(wr_seen == e_wr, e_wr ? "R6" : "R5", "write issued", 64'(wr_seen), 64'(e_wr));
    if (e_wr) begin
      chk(s_waddr == e_waddr, "R6", "write address", 64'(s_waddr), 64'(e_waddr));
      chk(s_wdata == e_wdata, "R4", "write data", s_wdata, e_wdata);
    end
    chk(fill_seen == e_fill, e_wr ? "R9" : "R7", "fill issued", 64'(fill_seen), 64'(e_fill));
    if (e_fill) begin
      chk(s_fpte == e_fpte, "R8", "fill entry", s_fpte, e_fpte);
      chk(s_fpaddr == wpa && s_fpa_addr == waddr, "R7", "fill addresses", 64'(s_fpaddr), 64'(wpa));
      chk(order_ok, "R8", "fill after write", 64'(order_ok), 64'd1);
    end
    chk(upd_seen == e_upd, "R10", "cache rewrite issued", 64'(upd_seen), 64'(e_upd));
    if (e_upd) chk(s_upte == e_fpte, "R10", "rewrite entry", s_upte, e_fpte);
    #1;
    chk(!done && req_ready, "R12", "pulse ended, ready", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; req_valid = 0; req_vaddr = '0; req_acc = 0; req_user = 0;
    cfg_hw_ad = 0; cfg_mxr = 0; cfg_sum = 0;
    cache_hit = 0; cache_pte = '0; cache_pte_addr = '0; cache_paddr = '0;
    walk_done = 0; walk_fault = 0; walk_code = 0; walk_pte = '0; walk_pte_addr = '0; walk_paddr = '0;
    mem_wr_done = 0; mem_wr_err = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !walk_start && !mem_wr_valid && !cache_fill && !cache_upd,
        "R1", "reset outputs", {58'd0, req_ready, done, walk_start, mem_wr_valid, cache_fill, cache_upd},
        64'h20);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !done, "R1", "idle after reset", {62'd0, req_ready, done}, 64'h2);

    // Directed corners: hit, load, A set -> address
    run_txn(1, 64'h0000_1234_0000_0043, 0, 0, 64'h0, 2'd0, 0, 0, 0, 1, 0);
    // hit store D=0, hw update -> write + rewrite
    run_txn(1, 64'h0000_5555_0000_0047, 0, 0, 64'h0, 2'd1, 0, 0, 0, 1, 0);
    // hit store D=0, hw update off -> code 5
    run_txn(1, 64'h0000_5555_0000_0047, 0, 0, 64'h0, 2'd1, 0, 0, 0, 0, 0);
    // hit update with write error -> code 1
    run_txn(1, 64'h0000_0000_0000_0003, 0, 0, 64'h0, 2'd0, 0, 0, 0, 1, 1);
    // miss, no update -> fill
    run_txn(0, 64'h0, 0, 0, 64'h0000_7777_0000_00C7, 2'd1, 0, 0, 0, 0, 0);
    // miss, A=0 load, update -> write then fill with updated entry
    run_txn(0, 64'h0, 0, 0, 64'h0000_7777_0000_000B, 2'd3, 0, 0, 0, 1, 0);
    // miss, update, write error -> code 1, no fill
    run_txn(0, 64'h0, 0, 0, 64'h0000_7777_0000_0007, 2'd1, 0, 0, 0, 1, 1);
    // walker fault passthrough
    run_txn(0, 64'h0, 1, 3'd3, 64'h0, 2'd0, 0, 0, 0, 1, 0);
    run_txn(0, 64'h0, 1, 3'd7, 64'h0, 2'd2, 1, 0, 0, 1, 0);
    // user on supervisor page -> code 4
    run_txn(1, 64'h0000_0000_0000_00CF, 0, 0, 64'h0, 2'd0, 1, 0, 0, 1, 0);
    // supervisor load of user page with sum -> ok; fetch with sum -> fault
    run_txn(1, 64'h0000_0000_0000_00DB, 0, 0, 64'h0, 2'd0, 0, 0, 1, 1, 0);
    run_txn(1, 64'h0000_0000_0000_00DB, 0, 0, 64'h0, 2'd2, 0, 0, 1, 1, 0);
    // execute-only page: load with mxr ok, without mxr fault
    run_txn(0, 64'h0, 0, 0, 64'h0000_0000_0000_00C9, 2'd0, 0, 1, 0, 1, 0);
    run_txn(0, 64'h0, 0, 0, 64'h0000_0000_0000_00C9, 2'd0, 0, 0, 0, 1, 0);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] cp, wp;
      cp = rnd64(); wp = rnd64();
      cp[0] = 1'b1; wp[0] = 1'b1;
      run_txn(($urandom_range(0, 1) == 1), cp, ($urandom_range(0, 5) == 0),
              3'(1 + $urandom_range(0, 6)), wp, 2'($urandom_range(0, 3)),
              ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1),
              ($urandom_range(0, 1) == 1), ($urandom_range(0, 2) != 0),
              ($urandom_range(0, 4) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule